// File: doc/BRIEF.md
# Dual-Lane Serial ADC Result Reader

This block is the host-side master for an eight-channel converter whose results come out serially. It drives a chip-select and a serial clock it derives from the system clock, and it shifts in 18-bit channel results on up to two data lanes. In dual-lane mode one lane carries channels 1 to 4 and the other carries channels 5 to 8, each most significant bit first, so a frame takes 72 serial clocks. In single-lane mode all eight channels arrive on lane A in 144 serial clocks. When the frame is complete, the block presents all eight results as one packed word together with a one-cycle strobe.

The converter marks the start of a frame with a first-channel flag. The reader samples this flag at the end of the chip-select setup time and abandons the frame if the flag is low. A read can be issued after a conversion has finished, in which case it waits for the converter's busy signal to drop. It can also be issued during a conversion. In that case the reader counts how long busy has been high and admits the read only if the whole frame, plus a guard window, ends before the expected end of the conversion. A read that cannot meet this limit is refused with a pulse and then runs as soon as busy falls.

Top module: `dual_lane_adc_reader`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, and `frame_valid`, `frame_err` and `deferred` are 0.
- R2: During a frame, every `sclk` high phase and every low phase between two rising edges lasts exactly HALF_CYC system clocks. `sclk` is 0 whenever `cs_n` is 1.
- R3: `cs_n` falls exactly SETUP_CYC clocks before the first `sclk` rising edge. It rises exactly HOLD_CYC clocks after the last `sclk` falling edge.
- R4: In dual-lane mode (`single_lane`=0) a frame has 72 `sclk` pulses. Lane A and lane B are captured on each falling edge, MSB first. Lane A delivers channels 1..4 and lane B delivers channels 5..8. In `frame_data`, channel n (1..8) occupies bits [161-18n : 144-18n], so channel 1 sits in bits 143:126 and channel 8 in bits 17:0.
- R5: In single-lane mode (`single_lane`=1) a frame has 144 `sclk` pulses. All eight channels are taken from lane A with the same packing, and lane B has no effect.
- R6: `frame_valid` is a one-cycle pulse in the cycle where `cs_n` returns to 1 at the end of a complete frame, and `frame_data` holds the frame at that point.
- R7: `frstdata` is sampled on the clock edge that would raise the first `sclk`. If it is 0, no `sclk` pulse is produced, `cs_n` returns to 1 on that edge, `frame_err` pulses for one cycle and `frame_valid` stays 0.
- R8: A request with `during_conv`=0 while the synchronized `busy` is 1 keeps `cs_n` high until `busy` is low and then reads. It does not pulse `deferred`.
- R9: A request with `during_conv`=1 while busy is high is admitted when elapsed busy-high cycles + frame length + GUARD_CYC ≤ CONV_CYC. Chip-select then falls on the next clock while busy is still high.
- R10: A request with `during_conv`=1 that fails the R9 limit pulses `deferred` for one cycle and keeps `cs_n` high while busy is high. Once busy falls it performs the read. With the default parameters a single-lane frame is always refused.
- R11: A `start` pulse that arrives while a request is pending or a frame is in progress has no effect: exactly one frame results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle read request |
| during_conv | input | 1 | Request targets the conversion in progress |
| single_lane | input | 1 | 1: all channels on lane A; 0: two lanes |
| busy | input | 1 | Converter busy (asynchronous, synchronized inside) |
| frstdata | input | 1 | First-channel flag from converter |
| douta | input | 1 | Serial data lane A |
| doutb | input | 1 | Serial data lane B |
| cs_n | output | 1 | Chip-select, active low |
| sclk | output | 1 | Serial clock, idles low |
| frame_valid | output | 1 | Frame complete strobe |
| frame_data | output | 144 | Eight packed 18-bit results, channel 1 highest |
| frame_err | output | 1 | First-channel flag missing at frame start |
| deferred | output | 1 | Read-during-conversion refused, postponed |

## Verification
The bench sweeps the lane packing with patterns that include all-ones and all-zeros words. A half-lane swap or an off-by-one bit count would scramble the channel order in `frame_data`. In single-lane mode lane B toggles with noise, so a design that still sampled lane B shows corrupted lower channels. The setup, hold and half-period counts are measured at the pins, which catches a counter that is one cycle short or long. Conversion reads are placed well inside and well outside the admission window. An admission check with the wrong sense would either start chip-select while the late conversion is busy or pulse `deferred` for a read that fits. A missing first-channel flag and a second `start` issued mid-frame check that the reader neither clocks a bad frame nor runs a second, unrequested one.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_SETUP = 3'd2,
    ST_SHIFT = 3'd3,
    ST_HOLD  = 3'd4
  } rdr_state_e;

  // Clocks needed by one frame: setup, two halves per bit, hold.
  function automatic int frame_cycles(input int setup_c, input int half_c,
                                      input int bits, input int hold_c);
    return setup_c + 2 * half_c * bits + hold_c;
  endfunction

endpackage

// File: rtl/rdr_busy_track.sv
module rdr_busy_track #(
  parameter int CONV_CYC = 1000,
  localparam int EW      = $clog2(CONV_CYC + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  output logic          busy_s,
  output logic [EW-1:0] elapsed
);

  logic          meta_q, sync_q;
  logic [EW-1:0] elap_q, elap_d;
  logic          elap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= busy;
      sync_q <= meta_q;
    end
  end

  // Saturating count of cycles that the synchronized busy has been high.
  always_comb begin
    elap_en = 1'b0;
    elap_d  = elap_q;
    if (!sync_q) begin
      elap_en = (elap_q != '0);
      elap_d  = '0;
    end else if (elap_q != {EW{1'b1}}) begin
      elap_en = 1'b1;
      elap_d  = elap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       elap_q <= '0;
    else if (elap_en) elap_q <= elap_d;
  end

  assign busy_s  = sync_q;
  assign elapsed = elap_q;

endmodule

// File: rtl/rdr_sclk_gen.sv
module rdr_sclk_gen #(
  parameter int HALF_CYC = 5,
  localparam int HW      = $clog2(HALF_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic last,
  output logic sclk,
  output logic cap,
  output logic done
);

  logic          act_q, act_d;
  logic          sclk_q, sclk_d;
  logic [HW-1:0] cnt_q, cnt_d;
  logic          ph_end;

  assign ph_end = (cnt_q == HW'(HALF_CYC - 1));
  assign cap    = act_q & sclk_q & ph_end;
  assign done   = cap & last;

  always_comb begin
    act_d  = act_q;
    sclk_d = sclk_q;
    cnt_d  = cnt_q;
    if (!act_q) begin
      sclk_d = 1'b0;
      cnt_d  = '0;
      if (launch) begin
        act_d  = 1'b1;
        sclk_d = 1'b1;
      end
    end else if (ph_end) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
      if (cap && last) act_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_d;
      sclk_q <= sclk_d;
      cnt_q  <= cnt_d;
    end
  end

  assign sclk = sclk_q;

endmodule

// File: rtl/rdr_shifter.sv
module rdr_shifter #(
  parameter int LANE_W  = 72,
  localparam int WORD_W = 2 * LANE_W,
  localparam int BW     = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap,
  input  logic              single,
  input  logic              lane_a,
  input  logic              lane_b,
  output logic [WORD_W-1:0] word,
  output logic              last
);

  logic [BW-1:0] bit_q, bit_d;
  logic          bit_en;
  logic [1:0]    half_in;
  logic [LANE_W-1:0] half_q [2];

  // half 1 = upper (channels 1..4), half 0 = lower (channels 5..8)
  assign half_in[0] = single ? lane_a : lane_b;
  assign half_in[1] = single ? half_q[0][LANE_W-1] : lane_a;

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   half_q[h] <= '0;
      else if (cap) half_q[h] <= {half_q[h][LANE_W-2:0], half_in[h]};
    end
  end

  assign word = {half_q[1], half_q[0]};
  assign last = single ? (bit_q == BW'(WORD_W - 1)) : (bit_q == BW'(LANE_W - 1));

  always_comb begin
    bit_en = clr | cap;
    bit_d  = clr ? '0 : bit_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bit_q <= '0;
    else if (bit_en) bit_q <= bit_d;
  end

endmodule

// File: rtl/dual_lane_adc_reader.sv
module dual_lane_adc_reader #(
  parameter int CH_BITS   = 18,
  parameter int N_CH      = 8,
  parameter int HALF_CYC  = 5,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int GUARD_CYC = 8,
  parameter int CONV_CYC  = 1000,
  localparam int WORD_W   = N_CH * CH_BITS,
  localparam int LANE_W   = WORD_W / 2,
  localparam int FR_DUAL  = rdr_pkg::frame_cycles(SETUP_CYC, HALF_CYC, LANE_W, HOLD_CYC),
  localparam int FR_SNGL  = rdr_pkg::frame_cycles(SETUP_CYC, HALF_CYC, WORD_W, HOLD_CYC),
  localparam int EW       = $clog2(CONV_CYC + 2),
  localparam int TMAX     = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC,
  localparam int TW       = $clog2(TMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              during_conv,
  input  logic              single_lane,
  input  logic              busy,
  input  logic              frstdata,
  input  logic              douta,
  input  logic              doutb,
  output logic              cs_n,
  output logic              sclk,
  output logic              frame_valid,
  output logic [WORD_W-1:0] frame_data,
  output logic              frame_err,
  output logic              deferred
);

  import rdr_pkg::*;

  rdr_state_e    st_q, st_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          single_q, single_d;
  logic          cs_n_q, cs_n_d;
  logic          fv_q, fv_d, fe_q, fe_d, df_q, df_d;
  logic          launch, clr, cap, last, done;
  logic          busy_s, fits;
  logic [EW-1:0] elapsed;
  logic [31:0]   need;

  rdr_busy_track #(.CONV_CYC(CONV_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .busy(busy), .busy_s(busy_s), .elapsed(elapsed)
  );

  rdr_sclk_gen #(.HALF_CYC(HALF_CYC)) u_sclk (
    .clk(clk), .rst_n(rst_n), .launch(launch), .last(last),
    .sclk(sclk), .cap(cap), .done(done)
  );

  rdr_shifter #(.LANE_W(LANE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cap(cap), .single(single_q),
    .lane_a(douta), .lane_b(doutb), .word(frame_data), .last(last)
  );

  // Admission test for a read inside the running conversion.
  always_comb begin
    need = 32'(elapsed) + 32'(single_lane ? FR_SNGL : FR_DUAL) + 32'(GUARD_CYC);
    fits = (need <= 32'(CONV_CYC));
  end

  always_comb begin
    st_d     = st_q;
    tcnt_d   = tcnt_q;
    single_d = single_q;
    cs_n_d   = cs_n_q;
    fv_d     = 1'b0;
    fe_d     = 1'b0;
    df_d     = 1'b0;
    launch   = 1'b0;
    clr      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          single_d = single_lane;
          if (!busy_s || (during_conv && fits)) begin
            st_d   = ST_SETUP;
            cs_n_d = 1'b0;
            tcnt_d = '0;
            clr    = 1'b1;
          end else begin
            st_d = ST_WAIT;
            df_d = during_conv;
          end
        end
      end
      ST_WAIT: begin
        if (!busy_s) begin
          st_d   = ST_SETUP;
          cs_n_d = 1'b0;
          tcnt_d = '0;
          clr    = 1'b1;
        end
      end
      ST_SETUP: begin
        if (tcnt_q == TW'(SETUP_CYC - 1)) begin
          if (frstdata) begin
            st_d   = ST_SHIFT;
            launch = 1'b1;
          end else begin
            st_d   = ST_IDLE;
            cs_n_d = 1'b1;
            fe_d   = 1'b1;
          end
        end else begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (done) begin
          st_d   = ST_HOLD;
          tcnt_d = '0;
        end
      end
      ST_HOLD: begin
        if (tcnt_q == TW'(HOLD_CYC - 1)) begin
          st_d   = ST_IDLE;
          cs_n_d = 1'b1;
          fv_d   = 1'b1;
        end else begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      default: begin
        st_d   = ST_IDLE;
        cs_n_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      tcnt_q   <= '0;
      single_q <= 1'b0;
      cs_n_q   <= 1'b1;
      fv_q     <= 1'b0;
      fe_q     <= 1'b0;
      df_q     <= 1'b0;
    end else begin
      st_q     <= st_d;
      tcnt_q   <= tcnt_d;
      single_q <= single_d;
      cs_n_q   <= cs_n_d;
      fv_q     <= fv_d;
      fe_q     <= fe_d;
      df_q     <= df_d;
    end
  end

  assign cs_n        = cs_n_q;
  assign frame_valid = fv_q;
  assign frame_err   = fe_q;
  assign deferred    = df_q;

endmodule

// File: rtl/rdr_checker.sv
module rdr_checker #(
  parameter int HALF_CYC  = 5,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic cs_n,
  input logic frame_valid,
  input logic frame_err,
  input logic deferred
);

  logic [15:0] hi_cnt, lo_cnt;
  logic        sclk_q, fell_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      lo_cnt    <= '0;
      sclk_q    <= 1'b0;
      fell_seen <= 1'b0;
    end else begin
      hi_cnt    <= sclk ? hi_cnt + 1'b1 : '0;
      lo_cnt    <= (sclk || cs_n) ? '0 : lo_cnt + 1'b1;
      sclk_q    <= sclk;
      fell_seen <= cs_n ? 1'b0 : (fell_seen | (sclk_q & ~sclk));
    end
  end

  // R2
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R2
  sclk_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> hi_cnt == 16'(HALF_CYC));

  // R2
  sclk_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && fell_seen) |-> lo_cnt == 16'(HALF_CYC));

  // R3
  cs_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && !fell_seen) |-> lo_cnt == 16'(SETUP_CYC));

  // R3
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> lo_cnt == 16'(HOLD_CYC));

  // R6
  valid_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $rose(cs_n));

  // R7
  err_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($rose(cs_n) && !fell_seen && !sclk_q));

  // R10
  defer_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deferred |-> cs_n);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_valid, frame_err, deferred}));

endmodule

bind dual_lane_adc_reader rdr_checker #(
  .HALF_CYC(HALF_CYC), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)
) u_rdr_checker (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
  .frame_valid(frame_valid), .frame_err(frame_err), .deferred(deferred)
);

// File: tb/test_dual_lane_adc_reader.sv
`timescale 1ns/1ps
module test_dual_lane_adc_reader;

  localparam int HALF  = 5;
  localparam int SETUP = 2;
  localparam int HOLD  = 2;
  localparam int CONV  = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, during_conv = 1'b0, single_lane = 1'b0;
  logic busy = 1'b0, frstdata = 1'b0, douta = 1'b0, doutb = 1'b0;
  logic cs_n, sclk, frame_valid, frame_err, deferred;
  logic [143:0] frame_data;

  always #2.5 clk = ~clk;

  dual_lane_adc_reader #(.HALF_CYC(HALF), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD),
                         .CONV_CYC(CONV)) i_dual_lane_adc_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .during_conv(during_conv),
    .single_lane(single_lane), .busy(busy), .frstdata(frstdata),
    .douta(douta), .doutb(doutb), .cs_n(cs_n), .sclk(sclk),
    .frame_valid(frame_valid), .frame_data(frame_data),
    .frame_err(frame_err), .deferred(deferred)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // ---------------- converter model ----------------
  logic [17:0]  ch [8];
  logic [143:0] exp_word;
  logic         mdl_single = 1'b0;
  logic         bad_first  = 1'b0;
  int           rcnt = 0, fcnt = 0;

  always_comb exp_word = {ch[0], ch[1], ch[2], ch[3], ch[4], ch[5], ch[6], ch[7]};

  initial forever begin
    @(negedge cs_n);
    rcnt = 0;
    fcnt = 0;
    #1 frstdata = !bad_first;
  end

  initial forever begin
    @(posedge sclk);
    rcnt = rcnt + 1;
    #1;
    if (rcnt >= 1 && rcnt <= 144) douta = exp_word[144 - rcnt];
    if (mdl_single) doutb = rcnt[0];
    else if (rcnt >= 1 && rcnt <= 72) doutb = exp_word[72 - rcnt];
  end

  initial forever begin
    @(negedge sclk);
    fcnt = fcnt + 1;
    if (fcnt == 18) #1 frstdata = 1'b0;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag,
                       input logic [143:0] act, input logic [143:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic set_pattern(input int p);
    for (int i = 0; i < 8; i++) begin
      case (p)
        0: ch[i] = 18'((i + 1) * 32'h1F3A5 ^ 32'h0AB1);
        1: ch[i] = i[0] ? 18'h3FFFF : 18'h00000;
        default: ch[i] = 18'((i * 32'h2B6D + 32'h155) ^ (32'h20001 >> i));
      endcase
    end
  endtask

  task automatic begin_conv(input int len);
    fork
      begin
        busy = 1'b1;
        repeat (len) @(negedge clk);
        busy = 1'b0;
      end
    join_none
  endtask

  // measurement results
  int m_setup, m_rises, m_hi_min, m_hi_max, m_lo_min, m_lo_max, m_hold;
  int m_valid, m_err, m_def, m_cs_busy, m_post_low;
  logic m_busy_csfall;
  logic [143:0] m_data;

  task automatic run_frame(input bit dc, input bit sl, input bit poke);
    int hi_run = 0, lo_run = 0, t = 0;
    bit prev_cs = 1'b1, prev_sclk = 1'b0, poked = 1'b0, ended = 1'b0;
    m_setup = 0; m_rises = 0; m_hold = -1;
    m_hi_min = 9999; m_hi_max = 0; m_lo_min = 9999; m_lo_max = 0;
    m_valid = 0; m_err = 0; m_def = 0; m_cs_busy = 0; m_post_low = 0;
    m_busy_csfall = 1'b0; m_data = '0;
    mdl_single = sl;
    during_conv = dc; single_lane = sl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!ended && t < 4000) begin
      if (!cs_n && prev_cs) m_busy_csfall = busy;
      if (!cs_n && busy) m_cs_busy++;
      if (!cs_n && !sclk && m_rises == 0) m_setup++;
      if (sclk) begin
        if (!prev_sclk) begin
          m_rises++;
          if (m_rises > 1) begin
            if (lo_run < m_lo_min) m_lo_min = lo_run;
            if (lo_run > m_lo_max) m_lo_max = lo_run;
          end
          lo_run = 0;
        end
        hi_run++;
      end else begin
        if (prev_sclk) begin
          if (hi_run < m_hi_min) m_hi_min = hi_run;
          if (hi_run > m_hi_max) m_hi_max = hi_run;
          hi_run = 0;
        end
        if (!cs_n && m_rises > 0) lo_run++;
      end
      if (cs_n && !prev_cs && m_rises > 0) m_hold = lo_run;
      if (deferred) m_def++;
      if (frame_err) begin m_err++; ended = 1'b1; end
      if (frame_valid) begin m_valid++; m_data = frame_data; ended = 1'b1; end
      prev_cs = cs_n; prev_sclk = sclk;
      if (start) start = 1'b0;
      if (poke && !poked && m_rises == 10) begin start = 1'b1; poked = 1'b1; end
      @(negedge clk);
      t++;
    end
    start = 1'b0;
    for (int k = 0; k < 30; k++) begin
      if (!cs_n) m_post_low++;
      if (frame_valid) m_valid++;
      @(negedge clk);
    end
  endtask

  task automatic check_timing(input int bits);
    check(m_rises == bits, "R4/R5 sclk pulse count", 144'(m_rises), 144'(bits));
    check(m_hi_min == HALF && m_hi_max == HALF, "R2 sclk high phase",
          144'(m_hi_max), 144'(HALF));
    check(m_lo_min == HALF && m_lo_max == HALF, "R2 sclk low phase",
          144'(m_lo_min), 144'(HALF));
    check(m_setup == SETUP, "R3 cs setup", 144'(m_setup), 144'(SETUP));
    check(m_hold == HOLD, "R3 cs hold", 144'(m_hold), 144'(HOLD));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(cs_n === 1'b1 && sclk === 1'b0, "R1 cs_n/sclk reset",
          144'({cs_n, sclk}), 144'(2'b10));
    check(frame_valid === 1'b0 && frame_err === 1'b0 && deferred === 1'b0,
          "R1 strobes reset", 144'({frame_valid, frame_err, deferred}), 144'(0));
  endtask

  task automatic t_dual(input int p);
    set_pattern(p);
    run_frame(1'b0, 1'b0, 1'b0);
    check_timing(72);
    check(m_valid == 1 && m_err == 0, "R6 one frame_valid", 144'(m_valid), 144'(1));
    check(m_data == exp_word, "R4 dual-lane data", m_data, exp_word);
  endtask

  task automatic t_single();
    set_pattern(2);
    run_frame(1'b0, 1'b1, 1'b0);
    check_timing(144);
    check(m_valid == 1, "R6 single frame_valid", 144'(m_valid), 144'(1));
    check(m_data == exp_word, "R5 single-lane data, lane B ignored", m_data, exp_word);
  endtask

  task automatic t_frame_err();
    set_pattern(0);
    bad_first = 1'b1;
    run_frame(1'b0, 1'b0, 1'b0);
    bad_first = 1'b0;
    check(m_err == 1 && m_valid == 0, "R7 frame_err without frame_valid",
          144'({m_err[3:0], m_valid[3:0]}), 144'(8'h10));
    check(m_rises == 0, "R7 no sclk on bad flag", 144'(m_rises), 144'(0));
    check(m_post_low == 0, "R7 cs_n back high", 144'(m_post_low), 144'(0));
  endtask

  task automatic t_conv_ok();
    set_pattern(0);
    begin_conv(CONV);
    repeat (20) @(negedge clk);
    run_frame(1'b1, 1'b0, 1'b0);
    check(m_def == 0, "R9 no deferred when fits", 144'(m_def), 144'(0));
    check(m_busy_csfall == 1'b1, "R9 read starts while busy", 144'(m_busy_csfall), 144'(1));
    check(busy == 1'b1 && m_valid == 1, "R9 frame ends before busy falls",
          144'({busy, m_valid[0]}), 144'(2'b11));
    check(m_data == exp_word, "R9 data", m_data, exp_word);
    wait (busy == 1'b0);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_conv_refuse(input bit sl, input int delay);
    set_pattern(1);
    begin_conv(CONV);
    repeat (delay) @(negedge clk);
    run_frame(1'b1, sl, 1'b0);
    check(m_def == 1, "R10 deferred pulse", 144'(m_def), 144'(1));
    check(m_cs_busy == 0, "R10 cs_n high while busy", 144'(m_cs_busy), 144'(0));
    check(m_valid == 1 && m_data == exp_word, "R10 read after busy falls",
          m_data, exp_word);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_wait_after();
    set_pattern(2);
    begin_conv(300);
    repeat (20) @(negedge clk);
    run_frame(1'b0, 1'b0, 1'b0);
    check(m_def == 0, "R8 no deferred on after-conversion request", 144'(m_def), 144'(0));
    check(m_cs_busy == 0, "R8 waits for busy low", 144'(m_cs_busy), 144'(0));
    check(m_valid == 1 && m_data == exp_word, "R8 data", m_data, exp_word);
  endtask

  task automatic t_poke();
    set_pattern(0);
    run_frame(1'b0, 1'b0, 1'b1);
    check(m_valid == 1, "R11 single frame despite extra start", 144'(m_valid), 144'(1));
    check(m_post_low == 0, "R11 no second frame", 144'(m_post_low), 144'(0));
    check(m_data == exp_word, "R11 data intact", m_data, exp_word);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    set_pattern(0);
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dual(0);
    t_dual(1);
    t_dual(2);
    t_single();
    t_frame_err();
    t_dual(2);
    t_conv_ok();
    t_conv_refuse(1'b0, 600);
    t_conv_refuse(1'b1, 20);
    t_wait_after();
    t_poke();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule